// File: doc/BRIEF.md
# Run-Length Serial Configuration Loader

This block loads a configuration image into a slave-serial programmable device. A host starts a sequence and then streams bytes over a valid/ready channel. The block pulls the device's program line low and waits for the device to acknowledge by dropping its init line. It then releases the program line and waits for init to return high. After that it shifts out a fixed 16-bit sync header and expands each host byte into a run of serial bits. Once the last byte has been sent, it waits for the device's done line.

Every byte is a run-length code rather than eight literal bits. A small code can stand for hundreds of ones, or a stretch of zeros closed by a one, so the host only supplies a compressed stream. Each serial bit takes four equal phases of the configuration clock, and each phase lasts a parameterised number of system clocks. Every wait has its own cycle budget. The result is a held finished flag and a two-bit outcome code: success, init never fell, init never rose, or done never came.

Top module: `sercfg_loader`

## Requirements
- R1: After reset, and whenever no sequence runs, prog_n_o, cclk_o and din_o are high, byte_ready_o is low, finished_o is low until the first sequence ends, and err_code_o is 0.
- R2: start_i drives prog_n_o low until init_n_i is seen low. If init_n_i does not fall within T_INIT_FALL cycles, the sequence ends with err_code_o = 1 and prog_n_o high.
- R3: Once init_n_i is low, prog_n_o goes high and the block waits for init_n_i high. If this does not happen within T_INIT_RISE cycles, the sequence ends with err_code_o = 2.
- R4: Each serial bit takes four phases of PH_CYC cycles each, in this order: cclk_o low with din_o high; cclk_o low with din_o at the bit; cclk_o high with din_o at the bit; cclk_o high with din_o high. The bit is therefore valid at the rising edge of cclk_o, and cclk_o stays low for 2*PH_CYC cycles.
- R5: Before any payload bit, the block sends the 16 header bits 1111_1111_0010_0000, leftmost first.
- R6: A byte code n with 1 <= n <= 226 emits n one-bits followed by one zero-bit.
- R7: Code 227 emits exactly 226 one-bits and no zero-bit.
- R8: A code c with 228 <= c <= 254 emits (c - 228) zero-bits followed by one one-bit, so 228 emits a single one-bit.
- R9: Code 255 emits a single one-bit. Code 0 emits no bit.
- R10: byte_ready_o is high only in the payload phase, while no bit of an earlier code is still waiting to be emitted, and while the byte marked by byte_last_i has not yet been taken.
- R11: After the bits of the last byte have been fully clocked out, done_i high ends the sequence with err_code_o = 0. If done_i does not go high within T_DONE cycles, the sequence ends with err_code_o = 3.
- R12: finished_o and err_code_o hold until the next start_i. A start_i pulse during a running sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a configuration sequence (honoured only when idle or finished) |
| byte_valid_i | input | 1 | Host byte is valid |
| byte_data_i | input | 8 | Run-length code byte |
| byte_last_i | input | 1 | Marks the final byte of the stream |
| byte_ready_o | output | 1 | Block accepts a byte this cycle |
| finished_o | output | 1 | Sequence has ended; held until next start |
| err_code_o | output | 2 | 0 ok, 1 init did not fall, 2 init did not rise, 3 done missing |
| prog_n_o | output | 1 | Device program line, active low |
| cclk_o | output | 1 | Device configuration clock |
| din_o | output | 1 | Device serial data |
| init_n_i | input | 1 | Device init line, active low |
| done_i | input | 1 | Device done line |

## Verification
Two things can happen in the same cycle. The expander can hand its last pending bit to the serializer, and the host can offer the next code. The bench keeps byte_valid_i asserted back to back across short and long codes, including 0 and 228, so each new code is offered on the first cycle byte_ready_o can rise. A scoreboard then compares every bit sampled at a rising cclk_o edge against the bits computed from the code rules. A lost bit, a duplicated bit or a clipped run shows up as a miscompare. A start_i pulse is also injected mid-run, and the same scoreboard shows that the stream is left untouched.

// File: rtl/sercfg_pkg.sv
// Shared types and constants for the run-length serial configuration loader.
// Assumes an 8-bit code alphabet and a fixed 16-bit sync header.
package sercfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG_LO,
        ST_PROG_REL,
        ST_HEADER,
        ST_PAYLOAD,
        ST_WAIT_DONE,
        ST_END
    } ld_state_t;

    localparam int unsigned    HDR_BITS = 16;
    localparam logic [15:0]    HDR_WORD = 16'hFF20;

    localparam logic [1:0] OUT_OK        = 2'd0;
    localparam logic [1:0] OUT_NO_FALL   = 2'd1;
    localparam logic [1:0] OUT_NO_RISE   = 2'd2;
    localparam logic [1:0] OUT_NO_DONE   = 2'd3;

endpackage

// File: rtl/sercfg_bitser.sv
// Bit serializer: sends one bit as four equal phases of PH_CYC clocks each:
// clock low / data high, clock low / data=bit, clock high / data=bit,
// clock high / data high. Idle level of clock and data is high.
// Assumes PH_CYC >= 1. Accepts a new bit only while idle (bit_rdy_o high).
module sercfg_bitser #(
    parameter int unsigned PH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld_i,
    input  logic bit_val_i,
    output logic bit_rdy_o,
    output logic cclk_o,
    output logic din_o
);
    localparam int unsigned CW = (PH_CYC > 1) ? $clog2(PH_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PH_CYC - 1);

    logic          busy;
    logic [1:0]    phase;
    logic [CW-1:0] cnt;
    logic          bit_q;

    // Phase sequencer: load a bit when idle, step phases, free after phase 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= 2'd0;
            cnt   <= '0;
            bit_q <= 1'b1;
        end else if (!busy) begin
            if (bit_vld_i) begin
                busy  <= 1'b1;
                phase <= 2'd0;
                cnt   <= '0;
                bit_q <= bit_val_i;
            end
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (phase == 2'd3) begin
                busy <= 1'b0;
            end else begin
                phase <= phase + 2'd1;
            end
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign bit_rdy_o = !busy;
    assign cclk_o    = !(busy && !phase[1]);
    assign din_o     = !(busy && (phase == 2'd1 || phase == 2'd2) && !bit_q);

    // Data must already be settled when the clock rises.
    assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(din_o));

    // Data is high in the first phase after the clock falls.
    assert_data_high_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cclk_o) |-> din_o);

endmodule

// File: rtl/sercfg_rle.sv
// Run-length expander: turns one code byte into a run of bits plus an
// optional closing bit. Codes 1..RUN_MAX give n ones then a zero;
// RUN_MAX+1 gives RUN_MAX ones; RUN_MAX+2..254 give (c-RUN_MAX-2) zeros then a one;
// 255 gives a single one; 0 gives nothing. Assumes load_i only while idle.
module sercfg_rle #(
    parameter int unsigned RUN_MAX = 226
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] code_i,
    input  logic       take_i,
    output logic       bit_vld_o,
    output logic       bit_val_o,
    output logic       busy_o
);
    localparam logic [7:0] RM8  = 8'(RUN_MAX);
    localparam logic [7:0] OVR8 = 8'(RUN_MAX + 1);
    localparam logic [7:0] ZB8  = 8'(RUN_MAX + 2);

    logic [7:0] run_cnt;
    logic       run_val;
    logic       tail;
    logic       tail_val;

    // Decode a code into run length and closing bit, then count bits out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            run_val  <= 1'b0;
            tail     <= 1'b0;
            tail_val <= 1'b0;
        end else if (load_i) begin
            if (code_i == 8'd0) begin
                run_cnt <= '0;
                tail    <= 1'b0;
            end else if (code_i <= RM8) begin
                run_cnt  <= code_i;
                run_val  <= 1'b1;
                tail     <= 1'b1;
                tail_val <= 1'b0;
            end else if (code_i == OVR8) begin
                run_cnt <= RM8;
                run_val <= 1'b1;
                tail    <= 1'b0;
            end else if (code_i == 8'hFF) begin
                run_cnt  <= '0;
                tail     <= 1'b1;
                tail_val <= 1'b1;
            end else begin
                run_cnt  <= code_i - ZB8;
                run_val  <= 1'b0;
                tail     <= 1'b1;
                tail_val <= 1'b1;
            end
        end else if (take_i && bit_vld_o) begin
            if (run_cnt != 8'd0) begin
                run_cnt <= run_cnt - 8'd1;
            end else begin
                tail <= 1'b0;
            end
        end
    end

    assign bit_vld_o = (run_cnt != 8'd0) || tail;
    assign bit_val_o = (run_cnt != 8'd0) ? run_val : tail_val;
    assign busy_o    = bit_vld_o;

    // A new code never overwrites bits still pending.
    assert_load_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);

    // A zero code leaves nothing to emit.
    assert_zero_code_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && code_i == 8'd0) |=> !busy_o);

    // Run length never exceeds the longest allowed run.
    assert_run_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RM8);

endmodule

// File: rtl/sercfg_loader.sv
// Top of the serial configuration loader. Runs the program/init handshake,
// sends the sync header, streams expanded codes, then waits for done.
// Assumes init_n_i and done_i are asynchronous (two-flop synchronised) and
// that the host marks exactly one final byte with byte_last_i.
module sercfg_loader
    import sercfg_pkg::*;
#(
    parameter int unsigned PH_CYC      = 4,
    parameter int unsigned T_INIT_FALL = 1000,
    parameter int unsigned T_INIT_RISE = 1000,
    parameter int unsigned T_DONE      = 100000,
    parameter int unsigned RUN_MAX     = 226
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_data_i,
    input  logic       byte_last_i,
    output logic       byte_ready_o,
    output logic       finished_o,
    output logic [1:0] err_code_o,
    output logic       prog_n_o,
    output logic       cclk_o,
    output logic       din_o,
    input  logic       init_n_i,
    input  logic       done_i
);
    localparam int unsigned TM1  = (T_INIT_FALL > T_INIT_RISE) ? T_INIT_FALL : T_INIT_RISE;
    localparam int unsigned TMAX = (TM1 > T_DONE) ? TM1 : T_DONE;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned HW   = $clog2(HDR_BITS + 1);

    ld_state_t     state;
    logic [TW-1:0] tmr;
    logic [15:0]   hdr_sr;
    logic [HW-1:0] hdr_left;
    logic          last_seen;
    logic [1:0]    outcome;
    logic [1:0]    init_q;
    logic [1:0]    done_q;
    logic          init_s;
    logic          done_s;

    logic ser_vld, ser_val, ser_rdy;
    logic exp_vld, exp_val, exp_busy, exp_take, exp_load;
    logic hdr_take;

    // Bring the asynchronous device status lines into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 2'b11;
            done_q <= 2'b00;
        end else begin
            init_q <= {init_q[0], init_n_i};
            done_q <= {done_q[0], done_i};
        end
    end
    assign init_s = init_q[1];
    assign done_s = done_q[1];

    assign hdr_take     = (state == ST_HEADER) && ser_rdy;
    assign exp_take     = (state == ST_PAYLOAD) && ser_rdy;
    assign byte_ready_o = (state == ST_PAYLOAD) && !exp_busy && !last_seen;
    assign exp_load     = byte_valid_i && byte_ready_o;

    // Select the bit source feeding the serializer.
    always_comb begin
        ser_vld = 1'b0;
        ser_val = 1'b1;
        if (state == ST_HEADER) begin
            ser_vld = 1'b1;
            ser_val = hdr_sr[15];
        end else if (state == ST_PAYLOAD) begin
            ser_vld = exp_vld;
            ser_val = exp_val;
        end
    end

    // Sequence control: handshake, header, payload, done wait, outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tmr       <= '0;
            hdr_sr    <= HDR_WORD;
            hdr_left  <= '0;
            last_seen <= 1'b0;
            outcome   <= OUT_OK;
        end else begin
            unique case (state)
                ST_IDLE, ST_END: begin
                    if (start_i) begin
                        state     <= ST_PROG_LO;
                        tmr       <= '0;
                        outcome   <= OUT_OK;
                        last_seen <= 1'b0;
                        hdr_sr    <= HDR_WORD;
                        hdr_left  <= HW'(HDR_BITS);
                    end
                end
                ST_PROG_LO: begin
                    if (!init_s) begin
                        state <= ST_PROG_REL;
                        tmr   <= '0;
                    end else if (tmr == TW'(T_INIT_FALL - 1)) begin
                        state   <= ST_END;
                        outcome <= OUT_NO_FALL;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                ST_PROG_REL: begin
                    if (init_s) begin
                        state <= ST_HEADER;
                    end else if (tmr == TW'(T_INIT_RISE - 1)) begin
                        state   <= ST_END;
                        outcome <= OUT_NO_RISE;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                ST_HEADER: begin
                    if (hdr_take) begin
                        hdr_sr   <= {hdr_sr[14:0], 1'b0};
                        hdr_left <= hdr_left - HW'(1);
                        if (hdr_left == HW'(1)) begin
                            state <= ST_PAYLOAD;
                        end
                    end
                end
                ST_PAYLOAD: begin
                    if (exp_load && byte_last_i) begin
                        last_seen <= 1'b1;
                    end
                    if (last_seen && !exp_busy && ser_rdy) begin
                        state <= ST_WAIT_DONE;
                        tmr   <= '0;
                    end
                end
                ST_WAIT_DONE: begin
                    if (done_s) begin
                        state   <= ST_END;
                        outcome <= OUT_OK;
                    end else if (tmr == TW'(T_DONE - 1)) begin
                        state   <= ST_END;
                        outcome <= OUT_NO_DONE;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign prog_n_o   = (state != ST_PROG_LO);
    assign finished_o = (state == ST_END);
    assign err_code_o = outcome;

    sercfg_rle #(
        .RUN_MAX (RUN_MAX)
    ) u_rle (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (exp_load),
        .code_i    (byte_data_i),
        .take_i    (exp_take),
        .bit_vld_o (exp_vld),
        .bit_val_o (exp_val),
        .busy_o    (exp_busy)
    );

    sercfg_bitser #(
        .PH_CYC (PH_CYC)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld_i (ser_vld),
        .bit_val_i (ser_val),
        .bit_rdy_o (ser_rdy),
        .cclk_o    (cclk_o),
        .din_o     (din_o)
    );

    // The host is never offered a slot while expanded bits are pending.
    assert_ready_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exp_busy |-> !byte_ready_o);

    // No configuration clock activity while the program line is held low.
    assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> (cclk_o && din_o));

    // A successful finish is caused by a seen done level.
    assert_ok_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(finished_o) && err_code_o == OUT_OK) |-> $past(done_s));

    // Outcome holds until the next start request.
    assert_outcome_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (finished_o && !start_i) |=> (finished_o && $stable(err_code_o)));

endmodule

// File: tb/sercfg_loader_bench.sv
module sercfg_loader_bench;
    localparam int unsigned PH  = 2;
    localparam int unsigned TF  = 40;
    localparam int unsigned TR  = 40;
    localparam int unsigned TD  = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_data_i = 8'd0;
    logic       byte_last_i = 1'b0;
    logic       byte_ready_o;
    logic       finished_o;
    logic [1:0] err_code_o;
    logic       prog_n_o;
    logic       cclk_o;
    logic       din_o;
    logic       init_n;
    logic       done_i = 1'b0;

    logic m_nofall = 1'b0;
    logic m_norise = 1'b0;

    int checks = 0;
    int fails  = 0;
    int m_checks = 0;
    int m_fails  = 0;
    bit exp_q[$];

    always #5 clk = ~clk;

    sercfg_loader #(
        .PH_CYC      (PH),
        .T_INIT_FALL (TF),
        .T_INIT_RISE (TR),
        .T_DONE      (TD),
        .RUN_MAX     (226)
    ) u_sercfg_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .byte_data_i  (byte_data_i),
        .byte_last_i  (byte_last_i),
        .byte_ready_o (byte_ready_o),
        .finished_o   (finished_o),
        .err_code_o   (err_code_o),
        .prog_n_o     (prog_n_o),
        .cclk_o       (cclk_o),
        .din_o        (din_o),
        .init_n_i     (init_n),
        .done_i       (done_i)
    );

    // Device model: init follows the program line after a short delay.
    int dly = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            init_n <= 1'b1;
            dly    <= 0;
        end else if (!prog_n_o) begin
            if (init_n && !m_nofall) begin
                if (dly == 4) begin init_n <= 1'b0; dly <= 0; end
                else dly <= dly + 1;
            end else dly <= 0;
        end else if (!init_n && !m_norise) begin
            if (dly == 4) begin init_n <= 1'b1; dly <= 0; end
            else dly <= dly + 1;
        end else dly <= 0;
    end

    // Monitor: pops expected bits at each rising cclk and checks phase shape.
    logic prev_cclk = 1'b1;
    int   low_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cclk_o && prev_cclk) begin
                m_checks++;
                if (din_o !== 1'b1) begin
                    m_fails++;
                    $display("FAIL R4 din at clock fall: actual %0b expected 1", din_o);
                end
            end
            if (cclk_o && !prev_cclk) begin
                m_checks++;
                if (low_len != 2 * PH) begin
                    m_fails++;
                    $display("FAIL R4 clock low length: actual %0d expected %0d", low_len, 2 * PH);
                end
                m_checks++;
                if (exp_q.size() == 0) begin
                    m_fails++;
                    $display("FAIL R5 unexpected bit: actual %0b expected none", din_o);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    if (din_o !== e) begin
                        m_fails++;
                        $display("FAIL R6 stream bit: actual %0b expected %0b", din_o, e);
                    end
                end
            end
        end
        low_len   <= cclk_o ? 0 : low_len + 1;
        prev_cclk <= cclk_o;
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks + m_checks + 1, fails + m_fails + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push_bits(input int n, input bit v);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    // Expected expansion, computed from the code rules.
    task automatic push_code(input int c);
        if (c == 0) begin
        end else if (c <= 226) begin
            push_bits(c, 1'b1); push_bits(1, 1'b0);
        end else if (c == 227) begin
            push_bits(226, 1'b1);
        end else if (c == 255) begin
            push_bits(1, 1'b1);
        end else begin
            push_bits(c - 228, 1'b0); push_bits(1, 1'b1);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic begin_cfg();
        logic [15:0] h;
        h = 16'hFF20;
        for (int i = 15; i >= 0; i--) exp_q.push_back(h[i]);
        done_i = 1'b0;
        pulse_start();
    endtask

    // Driver: push expected bits, then hand the byte over.
    task automatic send_code(input int c, input bit last);
        push_code(c);
        byte_valid_i = 1'b1;
        byte_data_i  = 8'(c);
        byte_last_i  = last;
        @(negedge clk);
        while (!byte_ready_o) @(negedge clk);
        @(posedge clk);
        #1;
        byte_valid_i = 1'b0;
        byte_last_i  = 1'b0;
    endtask

    task automatic wait_finished(input int max_cyc);
        int n;
        n = 0;
        while (!finished_o && n < max_cyc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic drain_and_done();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4 * PH + 4) @(negedge clk);
        done_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset and idle levels
        chk(prog_n_o == 1'b1, "R1 prog_n after reset", prog_n_o, 1);
        chk(cclk_o == 1'b1, "R1 cclk after reset", cclk_o, 1);
        chk(din_o == 1'b1, "R1 din after reset", din_o, 1);
        chk(byte_ready_o == 1'b0, "R1 ready after reset", byte_ready_o, 0);
        chk(finished_o == 1'b0, "R1 finished after reset", finished_o, 0);
        chk(err_code_o == 2'd0, "R1 code after reset", err_code_o, 0);

        // Full sequence with every code class.
        begin_cfg();
        @(negedge clk);
        chk(prog_n_o == 1'b0, "R2 prog_n low after start", prog_n_o, 0);
        chk(byte_ready_o == 1'b0, "R10 ready low before payload", byte_ready_o, 0);
        send_code(1, 1'b0);     // R6
        send_code(5, 1'b0);     // R6
        send_code(0, 1'b0);     // R9
        send_code(226, 1'b0);   // R6
        send_code(227, 1'b0);   // R7
        @(negedge clk);
        chk(byte_ready_o == 1'b0, "R10 ready low during run", byte_ready_o, 0);
        pulse_start();          // R12: ignored mid-run
        chk(prog_n_o == 1'b1, "R12 start ignored mid-run", prog_n_o, 1);
        send_code(228, 1'b0);   // R8
        send_code(229, 1'b0);   // R8
        send_code(240, 1'b0);   // R8
        send_code(254, 1'b0);   // R8
        send_code(255, 1'b0);   // R9
        send_code(0, 1'b0);     // R9
        send_code(3, 1'b1);     // R6
        @(negedge clk);
        chk(byte_ready_o == 1'b0, "R10 ready low after last", byte_ready_o, 0);
        drain_and_done();
        wait_finished(200);
        chk(finished_o == 1'b1, "R11 finished after done", finished_o, 1);
        chk(err_code_o == 2'd0, "R11 success code", err_code_o, 0);
        chk(exp_q.size() == 0, "R5 all bits emitted", exp_q.size(), 0);
        repeat (20) @(negedge clk);
        chk(finished_o == 1'b1 && err_code_o == 2'd0, "R12 outcome held", err_code_o, 0);
        chk(cclk_o == 1'b1 && din_o == 1'b1, "R1 idle lines high", {cclk_o, din_o}, 3);

        // Init never falls.
        m_nofall = 1'b1;
        exp_q.delete();
        pulse_start();
        chk(finished_o == 1'b0, "R12 finished cleared by start", finished_o, 0);
        wait_finished(TF + 50);
        chk(err_code_o == 2'd1, "R2 init-fall timeout code", err_code_o, 1);
        chk(prog_n_o == 1'b1, "R2 prog released after timeout", prog_n_o, 1);
        m_nofall = 1'b0;
        repeat (10) @(negedge clk);

        // Init never rises again.
        m_norise = 1'b1;
        pulse_start();
        wait_finished(TF + TR + 50);
        chk(err_code_o == 2'd2, "R3 init-rise timeout code", err_code_o, 2);
        chk(prog_n_o == 1'b1, "R3 prog high after release", prog_n_o, 1);
        m_norise = 1'b0;
        repeat (20) @(negedge clk);

        // Done never arrives.
        begin_cfg();
        send_code(255, 1'b1);
        wait_finished(2000 + TD);
        chk(finished_o == 1'b1, "R11 finished without done", finished_o, 1);
        chk(err_code_o == 2'd3, "R11 done timeout code", err_code_o, 3);
        chk(exp_q.size() == 0, "R9 single bit of 255 sent", exp_q.size(), 0);

        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks + m_checks, fails + m_fails);
        $finish;
    end
endmodule